// File: doc/BRIEF.md
# Reset-Time Strap Capture and Shared Address Pin Control

This block sits between the lowest address pins of the external program-memory bus and the chip core. While the chip is held in reset, those pins are inputs. Each one carries a weak pull-down, and its level is a configuration strap: the clock source and the clock frequency. A separate program-memory select pin carries a weak pull-up, and its level is captured at the same time.

When reset is released, the block freezes every strap into a register. It then turns the pull-downs off and hands the pins back to the address bus. The pull-up on the select pin is held for a short, fixed time after release, so that the pin can then serve as a general-purpose pin.

Outside reset, the block also controls the active-low memory chip-enable and the output enables of the shared pins in low-power mode. Low-power mode is defined as the CPU idle bit set, the wake interrupt negated and the sleep bit set. In this mode the memory chip-enable is negated. A shared pin is tri-stated only if it latched a 1. A pin that latched a 0 keeps driving its address bit.

The pad reset is synchronised through a chain of flip-flops. It asserts asynchronously and is released on a clock edge. The control is a three-state machine:

- ST_STRAP: reset is active. Straps are sampled on every clock, pins are inputs, pull-downs and pull-up are on, and the chip-enable is high.
- ST_HOLD_PU: straps are frozen and pins drive. The pull-up is still on, and a counter runs.
- ST_RUN: normal operation.

The transitions are:

- ST_STRAP → ST_HOLD_PU on the first clock at which the synchronised reset is high. That clock edge is the capture edge.
- ST_HOLD_PU → ST_RUN once the counter reaches the hold length.
- Any state → ST_STRAP asynchronously when the reset pad goes low.

Top module: `strap_capture_mux`

## Requirements
- R1: While in reset, including the synchronisation window after the pad rises, all shared-pin output enables are 0, all pull-downs are enabled, the select-pin pull-up is enabled and `mem_ce_n` is 1.
- R2: Straps are captured on the third rising clock edge after `rst_n_pad` rises, with the default two synchroniser stages. The values present at that edge are the ones kept.
- R3: After the capture edge, all pull-downs are off. Strap pad changes no longer affect `clk_src_ext`, `clk_freq_48`, `freq_code_err` or `prog_mem_ext`.
- R4: Strap pin 2 latched 0 gives `clk_src_ext`=0, meaning crystal operation at 24 MHz. Latched 1 gives `clk_src_ext`=1, meaning an external clock source.
- R5: Strap bits [1:0] latched as 00 give `clk_freq_48`=0, meaning 24 MHz. Latched as 11 they give `clk_freq_48`=1, meaning 48 MHz. The codes 01 and 10 are reserved. They give `clk_freq_48`=0 and set `freq_code_err`, which stays set until the next reset and is 0 during reset.
- R6: Outside reset, `addr_pad_oe[i]` is 0 exactly when pin i latched 1, `cpu_idle_i`=1, `wake_irq_i`=0 and `clk_sleep_i`=1.
- R7: Outside reset, a pin that latched 0 has its output enable at 1 under every combination of the low-power inputs.
- R8: The select pin is latched on the same capture edge. Latched 0 gives `prog_mem_ext`=1, meaning external program memory. Latched 1 gives `prog_mem_ext`=0, meaning internal ROM.
- R9: `psel_pu_en` stays 1 for exactly 4 clock cycles after the capture edge and is 0 from the fourth edge after capture onward.
- R10: Outside reset, `mem_ce_n` is 1 exactly when the low-power condition holds, and 0 otherwise.
- R11: Driving `rst_n_pad` low during operation returns all outputs to the R1 reset state at once, without waiting for a clock edge.
- R12: `addr_pad_o` always equals `core_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n_pad | input | 1 | Raw active-low reset from the pad |
| strap_pad_i | input | 3 | Pad input levels of the shared address pins (bit 2: clock source, bits 1:0: frequency) |
| psel_pad_i | input | 1 | Pad input level of the program-memory select pin |
| core_addr_i | input | 3 | Low address bits from the core memory interface |
| cpu_idle_i | input | 1 | CPU idle bit |
| wake_irq_i | input | 1 | Wake interrupt line, active high |
| clk_sleep_i | input | 1 | Sleep bit of the clock control register |
| addr_pad_o | output | 3 | Output value driven onto the shared pins |
| addr_pad_oe | output | 3 | Per-pin output enable |
| strap_pd_en | output | 3 | Per-pin weak pull-down enable |
| psel_pu_en | output | 1 | Weak pull-up enable of the select pin |
| mem_ce_n | output | 1 | Active-low program-memory chip-enable |
| clk_src_ext | output | 1 | Latched clock source: 1 for external |
| clk_freq_48 | output | 1 | Latched frequency: 1 for 48 MHz |
| freq_code_err | output | 1 | Sticky flag: a reserved frequency code was latched |
| prog_mem_ext | output | 1 | Status: 1 when external program memory is selected |

## Verification
The hardest situation to reach is a difference between the pad value present at the capture edge and the value present one edge earlier or later. The synchroniser hides which edge that is.

The stimulus writes fresh random strap values at every falling edge across the whole reset release. It sets the intended pattern only on the half cycle before the third edge, and changes the pads again right after that edge. An off-by-one capture therefore shows up as a wrong clock source, frequency or error bit.

The low-power per-pin tri-state is reached by sweeping all eight combinations of the idle, wake and sleep inputs after each release. The releases cover patterns where each strap pin latched a 0 and patterns where it latched a 1. One reset is asserted mid-run, away from any clock edge, to test the asynchronous return.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        ST_STRAP   = 2'd0,
        ST_HOLD_PU = 2'd1,
        ST_RUN     = 2'd2
    } strap_state_e;

    // Frequency code helpers: all zeros is the base rate, all ones the doubled
    // rate, anything else is reserved.
    function automatic logic freq_is_fast(input logic [1:0] code);
        return &code;
    endfunction

    function automatic logic freq_is_reserved(input logic [1:0] code);
        return (|code) & ~(&code);
    endfunction

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_async,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n_async) begin
                if (!rst_n_async) chain_q <= '0;
                else              chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n_async) begin
                if (!rst_n_async) chain_q <= '0;
                else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/strap_ctrl_fsm.sv
module strap_ctrl_fsm
    import strap_pkg::*;
#(
    parameter int PU_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n_core,
    output logic sampling,
    output logic pu_hold
);
    localparam int CNT_W = (PU_HOLD > 1) ? $clog2(PU_HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PU_HOLD - 1);

    strap_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n_core) begin
        if (!rst_n_core) begin
            state_q <= ST_STRAP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STRAP: begin
                cnt_d   = '0;
                state_d = ST_HOLD_PU;
            end
            ST_HOLD_PU: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_STRAP;
        endcase
    end

    // Outputs
    always_comb begin
        sampling = 1'b0;
        pu_hold  = 1'b0;
        unique case (state_q)
            ST_STRAP:   begin sampling = 1'b1; pu_hold = 1'b1; end
            ST_HOLD_PU: begin sampling = 1'b0; pu_hold = 1'b1; end
            ST_RUN:     begin sampling = 1'b0; pu_hold = 1'b0; end
            default:    begin sampling = 1'b1; pu_hold = 1'b1; end
        endcase
    end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_pkg::*;
#(
    parameter int FREQ_W  = 2,
    parameter int STRAP_W = FREQ_W + 1
) (
    input  logic               clk,
    input  logic               rst_n_core,
    input  logic               sampling,
    input  logic [STRAP_W-1:0] strap_pad_i,
    input  logic               psel_pad_i,
    output logic [STRAP_W-1:0] strap_q,
    output logic               clk_src_ext,
    output logic               clk_freq_48,
    output logic               freq_code_err,
    output logic               prog_mem_ext
);
    logic              psel_q;
    logic              err_q;
    logic [FREQ_W-1:0] code_now;
    logic [FREQ_W-1:0] code_q;

    // The sample registers follow the pads for as long as the machine is in
    // the strap state, so the last edge spent there is the capture edge.
    always_ff @(posedge clk) begin
        if (sampling) begin
            strap_q <= strap_pad_i;
            psel_q  <= psel_pad_i;
        end
    end

    assign code_now = strap_pad_i[FREQ_W-1:0];
    assign code_q   = strap_q[FREQ_W-1:0];

    always_ff @(posedge clk or negedge rst_n_core) begin
        if (!rst_n_core)   err_q <= 1'b0;
        else if (sampling) err_q <= (|code_now) & ~(&code_now);
    end

    assign clk_src_ext   = strap_q[FREQ_W];
    assign clk_freq_48   = &code_q;
    assign freq_code_err = err_q;
    assign prog_mem_ext  = ~psel_q;
endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl #(
    parameter int STRAP_W = 3
) (
    input  logic               sampling,
    input  logic               low_power,
    input  logic [STRAP_W-1:0] strap_q,
    output logic [STRAP_W-1:0] pad_oe,
    output logic [STRAP_W-1:0] pad_pd_en
);
    generate
        for (genvar i = 0; i < STRAP_W; i++) begin : g_pin
            // A pin releases the bus in low-power mode only if its strap was 1.
            assign pad_oe[i]    = ~sampling & ~(strap_q[i] & low_power);
            assign pad_pd_en[i] = sampling;
        end
    endgenerate
endmodule

// File: rtl/strap_capture_mux.sv
module strap_capture_mux #(
    parameter int FREQ_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int PU_HOLD     = 4,
    localparam int STRAP_W    = FREQ_W + 1
) (
    input  logic               clk,
    input  logic               rst_n_pad,
    input  logic [STRAP_W-1:0] strap_pad_i,
    input  logic               psel_pad_i,
    input  logic [STRAP_W-1:0] core_addr_i,
    input  logic               cpu_idle_i,
    input  logic               wake_irq_i,
    input  logic               clk_sleep_i,
    output logic [STRAP_W-1:0] addr_pad_o,
    output logic [STRAP_W-1:0] addr_pad_oe,
    output logic [STRAP_W-1:0] strap_pd_en,
    output logic               psel_pu_en,
    output logic               mem_ce_n,
    output logic               clk_src_ext,
    output logic               clk_freq_48,
    output logic               freq_code_err,
    output logic               prog_mem_ext
);
    logic               rst_n_core;
    logic               sampling;
    logic               pu_hold;
    logic               low_power;
    logic [STRAP_W-1:0] strap_q;

    strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n_async (rst_n_pad),
        .rst_n_sync  (rst_n_core)
    );

    strap_ctrl_fsm #(.PU_HOLD(PU_HOLD)) u_fsm (
        .clk        (clk),
        .rst_n_core (rst_n_core),
        .sampling   (sampling),
        .pu_hold    (pu_hold)
    );

    strap_latch #(.FREQ_W(FREQ_W), .STRAP_W(STRAP_W)) u_latch (
        .clk           (clk),
        .rst_n_core    (rst_n_core),
        .sampling      (sampling),
        .strap_pad_i   (strap_pad_i),
        .psel_pad_i    (psel_pad_i),
        .strap_q       (strap_q),
        .clk_src_ext   (clk_src_ext),
        .clk_freq_48   (clk_freq_48),
        .freq_code_err (freq_code_err),
        .prog_mem_ext  (prog_mem_ext)
    );

    assign low_power = cpu_idle_i & ~wake_irq_i & clk_sleep_i;

    strap_pad_ctrl #(.STRAP_W(STRAP_W)) u_pads (
        .sampling  (sampling),
        .low_power (low_power),
        .strap_q   (strap_q),
        .pad_oe    (addr_pad_oe),
        .pad_pd_en (strap_pd_en)
    );

    assign addr_pad_o = core_addr_i;
    assign psel_pu_en = pu_hold;
    assign mem_ce_n   = sampling | low_power;
endmodule

// File: rtl/strap_capture_mux_chk.sv
module strap_capture_mux_chk #(
    parameter int STRAP_W = 3
) (
    input logic               clk,
    input logic               rst_n_pad,
    input logic               cpu_idle_i,
    input logic               wake_irq_i,
    input logic               clk_sleep_i,
    input logic [STRAP_W-1:0] addr_pad_oe,
    input logic [STRAP_W-1:0] strap_pd_en,
    input logic               psel_pu_en,
    input logic               mem_ce_n,
    input logic               clk_src_ext,
    input logic               clk_freq_48,
    input logic               freq_code_err
);
    logic lp;
    assign lp = cpu_idle_i & ~wake_irq_i & clk_sleep_i;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_pad)
        (strap_pd_en != '0) |-> (addr_pad_oe == '0 && mem_ce_n && psel_pu_en));

    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n_pad)
        (strap_pd_en == '0) |=> $stable(clk_src_ext));

    p_err_default_r5: assert property (@(posedge clk) disable iff (!rst_n_pad)
        freq_code_err |-> !clk_freq_48);

    p_tristate_r6: assert property (@(posedge clk) disable iff (!rst_n_pad)
        (strap_pd_en == '0 && lp && clk_src_ext) |-> !addr_pad_oe[STRAP_W-1]);

    p_drive_r7: assert property (@(posedge clk) disable iff (!rst_n_pad)
        (strap_pd_en == '0 && !clk_src_ext) |-> addr_pad_oe[STRAP_W-1]);

    p_pu_late_r9: assert property (@(posedge clk) disable iff (!rst_n_pad)
        $fell(psel_pu_en) |-> (strap_pd_en == '0));

    p_ce_r10: assert property (@(posedge clk) disable iff (!rst_n_pad)
        (strap_pd_en == '0) |-> (mem_ce_n == lp));
endmodule

bind strap_capture_mux strap_capture_mux_chk #(.STRAP_W(STRAP_W)) u_chk (
    .clk           (clk),
    .rst_n_pad     (rst_n_pad),
    .cpu_idle_i    (cpu_idle_i),
    .wake_irq_i    (wake_irq_i),
    .clk_sleep_i   (clk_sleep_i),
    .addr_pad_oe   (addr_pad_oe),
    .strap_pd_en   (strap_pd_en),
    .psel_pu_en    (psel_pu_en),
    .mem_ce_n      (mem_ce_n),
    .clk_src_ext   (clk_src_ext),
    .clk_freq_48   (clk_freq_48),
    .freq_code_err (freq_code_err)
);

// File: tb/strap_capture_mux_bench.sv
module strap_capture_mux_bench;
    logic       clk = 1'b0;
    logic       rst_n_pad = 1'b0;
    logic [2:0] strap_pad_i = 3'b000;
    logic       psel_pad_i = 1'b1;
    logic [2:0] core_addr_i = 3'b000;
    logic       cpu_idle_i = 1'b0;
    logic       wake_irq_i = 1'b0;
    logic       clk_sleep_i = 1'b0;
    logic [2:0] addr_pad_o, addr_pad_oe, strap_pd_en;
    logic       psel_pu_en, mem_ce_n, clk_src_ext, clk_freq_48, freq_code_err, prog_mem_ext;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    strap_capture_mux u_strap_capture_mux (
        .clk(clk), .rst_n_pad(rst_n_pad), .strap_pad_i(strap_pad_i), .psel_pad_i(psel_pad_i),
        .core_addr_i(core_addr_i), .cpu_idle_i(cpu_idle_i), .wake_irq_i(wake_irq_i),
        .clk_sleep_i(clk_sleep_i), .addr_pad_o(addr_pad_o), .addr_pad_oe(addr_pad_oe),
        .strap_pd_en(strap_pd_en), .psel_pu_en(psel_pu_en), .mem_ce_n(mem_ce_n),
        .clk_src_ext(clk_src_ext), .clk_freq_48(clk_freq_48),
        .freq_code_err(freq_code_err), .prog_mem_ext(prog_mem_ext)
    );

    // Behavioural reference: edges counted since the pad reset went high.
    int         edges = 0;
    logic [2:0] m_strap = 3'b000;
    logic       m_psel = 1'b1;
    logic       m_err = 1'b0;

    always @(posedge clk) begin
        if (!rst_n_pad) begin
            edges = 0;
        end else begin
            if (edges < 1000) edges = edges + 1;
            if (edges == 3) begin          // capture edge (R2)
                m_strap = strap_pad_i;
                m_psel  = psel_pad_i;
                m_err   = (strap_pad_i[1:0] == 2'b01) || (strap_pad_i[1:0] == 2'b10);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Compare on every clock, late in the low phase.
    always @(negedge clk) begin
        #3;
        if (!done) begin : cmp
            bit         rm;
            bit         lp;
            logic [2:0] e_oe;
            rm = !rst_n_pad || edges < 3;
            lp = cpu_idle_i && !wake_irq_i && clk_sleep_i;
            for (int i = 0; i < 3; i++) e_oe[i] = rm ? 1'b0 : !(m_strap[i] && lp);
            check(addr_pad_o == core_addr_i, "R12 addr passthrough", addr_pad_o, core_addr_i);
            check(strap_pd_en == (rm ? 3'b111 : 3'b000), rm ? "R1/R11 pull-down" : "R3 pull-down off",
                  strap_pd_en, rm ? 3'b111 : 3'b000);
            check(addr_pad_oe == e_oe, rm ? "R1/R11 oe" : "R6/R7 oe", addr_pad_oe, e_oe);
            check(psel_pu_en == (!rst_n_pad || edges < 7), "R9 pull-up", psel_pu_en,
                  int'(!rst_n_pad || edges < 7));
            check(mem_ce_n == (rm ? 1'b1 : lp), rm ? "R1 ce" : "R10 ce", mem_ce_n, rm ? 1 : int'(lp));
            check(freq_code_err == (rm ? 1'b0 : m_err), "R5 err", freq_code_err, rm ? 0 : int'(m_err));
            if (!rm) begin
                check(clk_src_ext == m_strap[2], "R4/R3 clk src", clk_src_ext, m_strap[2]);
                check(clk_freq_48 == (m_strap[1:0] == 2'b11), "R5/R3 freq", clk_freq_48,
                      int'(m_strap[1:0] == 2'b11));
                check(prog_mem_ext == !m_psel, "R8 prog select", prog_mem_ext, int'(!m_psel));
            end
        end
    end

    // One release with pattern {psel, strap[2:0]} present at the capture edge (R2).
    task automatic run_case(input logic [3:0] pat, input int reset_cycles);
        @(negedge clk);
        rst_n_pad = 1'b0;                 // mid-cycle assert (R11)
        for (int c = 0; c < reset_cycles; c++) begin
            @(negedge clk);
            {psel_pad_i, strap_pad_i} = 4'($urandom);
        end
        rst_n_pad = 1'b1;
        @(negedge clk);
        {psel_pad_i, strap_pad_i} = 4'($urandom);
        @(negedge clk);
        {psel_pad_i, strap_pad_i} = pat;
        @(negedge clk);
        {psel_pad_i, strap_pad_i} = ~pat; // after capture: ignored (R3)
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            {cpu_idle_i, wake_irq_i, clk_sleep_i} = 3'(s);
            core_addr_i = 3'($urandom);
            {psel_pad_i, strap_pad_i} = 4'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_case(4'b1000, 4);  // crystal, 24 MHz, internal ROM
        run_case(4'b0111, 3);  // external clock, 48 MHz, external memory
        run_case(4'b1101, 5);  // reserved 01
        run_case(4'b0010, 2);  // reserved 10, crystal
        run_case(4'b1111, 1);
        run_case(4'b0100, 6);  // pins 1:0 latched 0 stay driven in low power
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule